// File: doc/BRIEF.md
# Serial Ones-Residue and Even-Zeros Detector

This block watches a one-bit serial stream, taking at most one bit per clock. It keeps the number of 1s seen so far as a residue modulo three. It sorts the number of 0s seen so far into one of three classes: none yet, odd, or even and nonzero. The `match` flag is raised when the ones count is a multiple of three and the zeros count is even and at least two. Both counts cover every bit accepted since the last reset.

A bit is accepted only on a cycle where `bit_vld` is high. The input has no back-pressure: the block never stalls, so every strobed bit is consumed in the cycle it is presented. The parameter `MEALY_MODE` selects how the flag is produced. With 0, the flag comes from the registered state and moves only after a clock edge. With 1, the flag is a combinational output of the transition taken in the current cycle: it is high in the cycle whose accepted bit leads into a qualifying state.

Top module: `serial_tally_detect`

## Requirements
- R1: Each accepted 1 advances the ones residue by one, wrapping from 2 back to 0. An accepted 0 leaves the residue unchanged.
- R2: An accepted 0 moves the zeros class from none to odd, from odd to even-nonzero, and from even-nonzero to odd. An accepted 1 leaves the class unchanged. Once any 0 has been accepted, the none class is not entered again until reset.
- R3: A state qualifies exactly when the ones residue is 0 and the zeros class is even-nonzero. Examples are (ones, zeros) = (0,2), (3,2), (3,4) and (6,4). A stream with three 1s and no 0s does not qualify.
- R4: `rst` is synchronous and active high, and it takes priority over `bit_vld`. It puts the state at residue 0 with no zeros seen, and in that state `match` is 0.
- R5: On a cycle with `bit_vld` low, the state does not change, whatever value `bit_in` has.
- R6: With `MEALY_MODE`=0, `match` is 1 in the cycle after the edge that enters a qualifying state. It stays constant across cycles with `bit_vld` low.
- R7: With `MEALY_MODE`=1, `match` is 1 in the same cycle as an accepted bit whose transition ends in a qualifying state. It is 0 in any cycle with `bit_vld` low.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Strobe: `bit_in` is accepted this cycle |
| bit_in | input | 1 | Serial data bit |
| match | output | 1 | Detection flag, timing set by `MEALY_MODE` |

## Verification
The bench goes after the reset state, where the ones count is already a multiple of three but no 0 has arrived. A design that ignored the zeros class would raise the flag there, and again after three 1s with no 0s. It drives idle cycles that carry `bit_in`=1 inside a qualifying run. A design that counted unstrobed bits would move its residue, and a Mealy flag that was not gated by the strobe would stay high. It also checks the 2-to-0 residue wrap, the odd/even toggling of the zeros class out to six zeros, and a reset applied while a strobed bit is present. A design that let the strobe win over reset would not return to the cleared state.

// File: rtl/tally_pkg.sv
package tally_pkg;
  localparam int RES_W   = 2;
  localparam int RES_MOD = 3;

  typedef enum logic [1:0] {
    ZC_NONE = 2'b00,
    ZC_ODD  = 2'b01,
    ZC_EVEN = 2'b10
  } zcls_e;
endpackage

// File: rtl/ones_residue_next.sv
module ones_residue_next #(
  parameter int W   = 2,
  parameter int MOD = 3
) (
  input  logic [W-1:0] cur,
  input  logic         advance,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] TOP = W'(MOD - 1);

  always_comb begin
    if (!advance)        nxt = cur;
    else if (cur == TOP) nxt = '0;
    else                 nxt = cur + W'(1);
  end
endmodule

// File: rtl/zero_class_next.sv
module zero_class_next
  import tally_pkg::*;
(
  input  zcls_e cur,
  input  logic  step,
  output zcls_e nxt
);
  always_comb begin
    nxt = cur;
    if (step) begin
      unique case (cur)
        ZC_NONE: nxt = ZC_ODD;
        ZC_ODD:  nxt = ZC_EVEN;
        ZC_EVEN: nxt = ZC_ODD;
        default: nxt = ZC_ODD;
      endcase
    end
  end
endmodule

// File: rtl/hit_decode.sv
module hit_decode
  import tally_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [W-1:0] res,
  input  zcls_e        zc,
  input  logic         gate,
  output logic         hit
);
  assign hit = gate && (res == '0) && (zc == ZC_EVEN);
endmodule

// File: rtl/serial_tally_detect.sv
module serial_tally_detect
  import tally_pkg::*;
#(
  parameter bit MEALY_MODE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  output logic match
);
  logic [RES_W-1:0] res_q, res_d;
  zcls_e            zc_q, zc_d;

  ones_residue_next #(.W(RES_W), .MOD(RES_MOD)) u_res (
    .cur(res_q), .advance(bit_vld & bit_in), .nxt(res_d)
  );

  zero_class_next u_zc (
    .cur(zc_q), .step(bit_vld & ~bit_in), .nxt(zc_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      zc_q  <= ZC_NONE;
    end else begin
      res_q <= res_d;
      zc_q  <= zc_d;
    end
  end

  generate
    if (MEALY_MODE) begin : g_mealy
      hit_decode #(.W(RES_W)) u_hit (
        .res(res_d), .zc(zc_d), .gate(bit_vld), .hit(match)
      );
    end else begin : g_moore
      hit_decode #(.W(RES_W)) u_hit (
        .res(res_q), .zc(zc_q), .gate(1'b1), .hit(match)
      );
    end
  endgenerate
endmodule

// File: rtl/tally_detect_chk.sv
module tally_detect_chk
  import tally_pkg::*;
#(
  parameter bit MEALY_MODE = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_vld,
  input logic             bit_in,
  input logic             match,
  input logic [RES_W-1:0] res_q,
  input zcls_e            zc_q
);
  // R4
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (res_q == '0 && zc_q == ZC_NONE && (MEALY_MODE || !match)));

  // R5
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> ($stable(res_q) && $stable(zc_q)));

  // R1
  one_wraps_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && bit_in && res_q == 2'd2) |=> (res_q == '0));

  // R2
  none_gone_chk: assert property (@(posedge clk) disable iff (rst)
    (zc_q != ZC_NONE) |=> (zc_q != ZC_NONE));

  // R2
  odd_to_even_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && !bit_in && zc_q == ZC_ODD) |=> (zc_q == ZC_EVEN));

  generate
    if (MEALY_MODE) begin : g_mealy_chk
      // R7
      mealy_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |-> !match);
    end else begin : g_moore_chk
      // R6
      moore_idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> $stable(match));
    end
  endgenerate
endmodule

bind serial_tally_detect tally_detect_chk #(.MEALY_MODE(MEALY_MODE)) chk_i (
  .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
  .match(match), .res_q(res_q), .zc_q(zc_q)
);

// File: tb/serial_tally_detect_tb_top.sv
module serial_tally_detect_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic match_moore, match_mealy;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_tally_detect #(.MEALY_MODE(1'b0)) dut_i (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .match(match_moore)
  );
  serial_tally_detect #(.MEALY_MODE(1'b1)) dut_mealy_i (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .match(match_mealy)
  );

  // {vld, bit, moore flag after edge, mealy flag before edge}
  localparam int NV = 16;
  localparam logic [3:0] VEC [NV] = '{
    4'b1000, 4'b1011, 4'b0110, 4'b1100,
    4'b1100, 4'b1111, 4'b1000, 4'b1011,
    4'b1100, 4'b1100, 4'b1111, 4'b1000,
    4'b1100, 4'b1000, 4'b1100, 4'b1111
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic b, input logic r,
                      input logic exp_moore, input logic exp_mealy, input string req);
    @(negedge clk);
    bit_vld = v; bit_in = b; rst = r;
    #3;
    if (!r) check({req, " mealy"}, match_mealy, exp_mealy);
    @(posedge clk);
    #3;
    check({req, " moore"}, match_moore, exp_moore);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #3;
    // R4 reset state: residue 0 but no zeros, flag low
    check("R4 reset moore", match_moore, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    #3;
    check("R4 idle mealy", match_mealy, 1'b0);

    // R1 R2 R3 R5 R6 R7 table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][3], VEC[i][2], 1'b0, VEC[i][1], VEC[i][0], "R1/R2/R3/R5/R6/R7 table");
    end

    // R4 reset wins over a strobed bit while the flag is high
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4 reset priority");
    // R3 three ones with no zeros does not qualify
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3 no zeros");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3 no zeros");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3 no zeros");
    // R5 unstrobed ones must not move the residue
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 idle one");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2 first zero odd");
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R2 second zero even");
    // R6 R7 idle keeps Moore flag, drops Mealy flag
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R6/R7 idle");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R6/R7 idle");
    // R2 a further zero returns to odd, never to none
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2 third zero");
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R2 fourth zero");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule